// File: doc/BRIEF.md
# DMA Master Control and Status Register

This block is the shared control word of a multi-channel DMA controller. It holds one master enable bit and two sticky error flags, one for an address error and one for a non-maskable interrupt. Software reaches it over a simple register bus with read and write strobes. The flags are set by hardware events. Software clears a flag with a two-step handshake: it must first see the flag as 1 in a read, and then write 0 to it.

The block combines the master enable, the two flags and each channel's own enable and transfer-end bits into one run-permit signal per channel. When the master enable falls from 1 to 0, the block emits a one-cycle abort pulse to every channel engine. When the chip enters standby, both flags and their read markers are wiped. The master enable keeps its value through standby.

Top module: `dma_master_ctl`

## Requirements
- R1: The register reads back the master enable at bit 0, the interrupt flag at bit 1 and the address-error flag at bit 2. Every bit above 2 reads 0, and writes to those bits are ignored.
- R2: For every channel i, ch_permit[i] is 1 exactly when the master enable is 1, ch_de[i] is 1, ch_te[i] is 0 and both flags are 0.
- R3: While either flag is 1, every ch_permit bit is 0, whatever the channel enables and the master enable are.
- R4: Writing 0 to a flag clears it only if an earlier read returned that flag as 1. Writing 0 without such a read leaves the flag at 1. Writing 1 to a flag never changes it.
- R5: After reset the whole register reads 0. While standby is high, both flags are forced to 0 on the next edge and their read markers are discarded.
- R6: One cycle after a clock edge at which the master enable goes from 1 to 0, abort_pulse is high for exactly one cycle. All ch_permit bits are 0 in that cycle.
- R7: A cycle with addr_err_evt high sets bit 2, and a cycle with nmi_evt high sets bit 1, at the next edge unless standby is high.
- R8: If a set event arrives in the same cycle as a valid clearing write, the flag stays 1 and its read marker is consumed. A new read returning 1 is then needed before a write of 0 can clear the flag.
- R9: Every register write loads bit 0 of the write data into the master enable, even while a flag is set.
- R10: Read markers are kept per flag. A read arms only the flags that were 1 in that read, so a flag set after the read survives a write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_rd | input | 1 | Register read strobe; arms the markers of flags read as 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Current register value |
| addr_err_evt | input | 1 | Address-error event, sets bit 2 |
| nmi_evt | input | 1 | Non-maskable interrupt event, sets bit 1 |
| standby | input | 1 | Standby entry, wipes both flags |
| ch_de | input | NUM_CH | Per-channel enable bits |
| ch_te | input | NUM_CH | Per-channel transfer-end bits |
| ch_permit | output | NUM_CH | Per-channel run permission |
| abort_pulse | output | 1 | One-cycle pulse after the master enable falls |

## Verification
The permit function is swept over all 256 combinations of the four channel enables and four transfer-end bits. The sweep is repeated for each state of the master enable and the two flags, which separates gating by the master enable from blocking by either flag. Directed sequences then exercise the clear handshake:
- a write of 0 without a prior read;
- a write of 1;
- a read before the second flag was set;
- an event that collides with the clearing write;
- standby between the read and the write.

Each sequence tells a correctly armed marker apart from one that is missing, shared between the flags or stale. A long run of mixed random strobes and events, checked against a cycle model kept in the bench, covers the orderings in between.

// File: rtl/dma_mc_pkg.sv
// Package: bit positions of the master control word and the flag count.
// Assumes the word is at least three bits wide.
package dma_mc_pkg;
    localparam int BIT_EN   = 0;   // master enable
    localparam int BIT_NMI  = 1;   // interrupt flag
    localparam int BIT_AERR = 2;   // address-error flag
    localparam int FLAG_CNT = 2;   // flags occupy BIT_NMI .. BIT_NMI+FLAG_CNT-1
    localparam int USED_W   = 3;   // number of implemented bits
endpackage

// File: rtl/dmc_sticky_flag.sv
// Sticky error flag with a read-armed clear.
// A read that sees the flag as 1 arms a marker. A later write of 0 clears
// the flag only while the marker is armed. Any clearing attempt consumes the
// marker. A set event beats a clear. Standby wipes both the flag and the marker.
module dmc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_evt,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic flag_q
);
    logic armed_q;
    logic clr_req;
    logic flag_d;
    logic armed_d;

    // Purpose: decode the clear request and the next flag and marker values.
    always_comb begin
        clr_req = wr_stb & ~wr_bit & armed_q;
        if (standby)
            flag_d = 1'b0;
        else if (set_evt)
            flag_d = 1'b1;
        else if (clr_req)
            flag_d = 1'b0;
        else
            flag_d = flag_q;
        armed_d = flag_d & ~clr_req & (armed_q | (rd_stb & flag_q));
    end

    // Purpose: hold the flag and its marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/dmc_master_en.sv
// Master enable bit with fall detection.
// Every write loads the enable from the write data.
// abort_pulse is high for the one cycle after the enable falls from 1 to 0.
module dmc_master_en (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic en_q,
    output logic abort_pulse
);
    logic en_prev_q;

    // Purpose: store the enable and its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            en_prev_q <= 1'b0;
        end else begin
            en_prev_q <= en_q;
            if (wr_stb)
                en_q <= wr_bit;
        end
    end

    // Purpose: flag the cycle right after a falling enable.
    always_comb abort_pulse = en_prev_q & ~en_q;
endmodule

// File: rtl/dmc_chan_gate.sv
// Per-channel permit gate.
// A channel runs only with the master enable on, no global block, its own
// enable set and its transfer-end clear. The gate is purely combinational.
module dmc_chan_gate #(
    parameter int NUM_CH = 4
) (
    input  logic              master_en,
    input  logic              global_block,
    input  logic [NUM_CH-1:0] de,
    input  logic [NUM_CH-1:0] te,
    output logic [NUM_CH-1:0] permit
);
    logic go;

    // Purpose: common term shared by every channel.
    always_comb go = master_en & ~global_block;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Purpose: permit for channel i.
        always_comb permit[i] = go & de[i] & ~te[i];
    end
endmodule

// File: rtl/dma_master_ctl.sv
// DMA master control/status register.
// Combines the master enable, two read-armed sticky flags and the
// per-channel gates. Assumes DATA_W >= 3 and single-cycle bus strobes.
module dma_master_ctl
    import dma_mc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              addr_err_evt,
    input  logic              nmi_evt,
    input  logic              standby,
    input  logic [NUM_CH-1:0] ch_de,
    input  logic [NUM_CH-1:0] ch_te,
    output logic [NUM_CH-1:0] ch_permit,
    output logic              abort_pulse
);
    logic                en_q;
    logic [FLAG_CNT-1:0] flags_q;
    logic [FLAG_CNT-1:0] evt_vec;
    logic                unused_wdata;

    // Purpose: map the events onto flag slots (slot 0 = bit 1, slot 1 = bit 2).
    always_comb begin
        evt_vec[BIT_NMI-1]  = nmi_evt;
        evt_vec[BIT_AERR-1] = addr_err_evt;
    end

    // Purpose: upper write bits have no storage.
    always_comb unused_wdata = &{1'b0, reg_wdata};

    dmc_master_en u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (reg_wr),
        .wr_bit      (reg_wdata[BIT_EN]),
        .en_q        (en_q),
        .abort_pulse (abort_pulse)
    );

    for (genvar f = 0; f < FLAG_CNT; f++) begin : g_flag
        dmc_sticky_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .standby (standby),
            .set_evt (evt_vec[f]),
            .rd_stb  (reg_rd),
            .wr_stb  (reg_wr),
            .wr_bit  (reg_wdata[BIT_NMI+f]),
            .flag_q  (flags_q[f])
        );
    end

    dmc_chan_gate #(.NUM_CH(NUM_CH)) u_gate (
        .master_en    (en_q),
        .global_block (|flags_q),
        .de           (ch_de),
        .te           (ch_te),
        .permit       (ch_permit)
    );

    // Purpose: assemble the readback word, unused bits zero.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[BIT_EN] = en_q;
        reg_rdata[BIT_NMI +: FLAG_CNT] = flags_q;
    end
endmodule

// File: rtl/dma_master_ctl_chk.sv
// Checker for dma_master_ctl. It observes only the ports and is bound to
// every instance of the block.
module dma_master_ctl_chk #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              addr_err_evt,
    input logic              nmi_evt,
    input logic              standby,
    input logic [NUM_CH-1:0] ch_de,
    input logic [NUM_CH-1:0] ch_te,
    input logic [NUM_CH-1:0] ch_permit,
    input logic              abort_pulse
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata >> 3) == '0);

    p_flag_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] || reg_rdata[1]) |-> ch_permit == '0);

    p_write1_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2] && reg_rdata[2] && !standby) |=> reg_rdata[2]);

    p_idle_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !standby && reg_rdata[1]) |=> reg_rdata[1]);

    p_standby_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> reg_rdata[2:1] == 2'b00);

    p_abort_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[0]) |-> abort_pulse);

    p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    p_abort_no_permit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> ch_permit == '0);

    p_aerr_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_err_evt && !standby) |=> reg_rdata[2]);

    p_nmi_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_evt && !standby) |=> reg_rdata[1]);

    p_write_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[0] == $past(reg_wdata[0]));
endmodule

bind dma_master_ctl dma_master_ctl_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_err_evt(addr_err_evt),
    .nmi_evt(nmi_evt), .standby(standby), .ch_de(ch_de), .ch_te(ch_te),
    .ch_permit(ch_permit), .abort_pulse(abort_pulse)
);

// File: tb/test_dma_master_ctl.sv
// Bench for dma_master_ctl. It drives the inputs on the falling edge and
// checks against a cycle model written from the requirements.
module test_dma_master_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_rd = 1'b0, reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          addr_err_evt = 1'b0, nmi_evt = 1'b0, standby = 1'b0;
    logic [NC-1:0] ch_de = '0, ch_te = '0;
    logic [NC-1:0] ch_permit;
    logic          abort_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    // cycle model of the register
    bit m_en, m_en_prev, m_ae, m_nmi, m_arm_ae, m_arm_nmi;

    dma_master_ctl #(.DATA_W(DW), .NUM_CH(NC)) i_dma_master_ctl (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_err_evt(addr_err_evt),
        .nmi_evt(nmi_evt), .standby(standby), .ch_de(ch_de), .ch_te(ch_te),
        .ch_permit(ch_permit), .abort_pulse(abort_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string ph, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", ph, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // One cycle: drive at the falling edge, check the outputs, advance the model.
    task automatic step(string ph, bit rd, bit wr, logic [DW-1:0] wd,
                        bit ae_e, bit nmi_e, bit sb,
                        logic [NC-1:0] de, logic [NC-1:0] te);
        logic [DW-1:0] exp_rd;
        logic [NC-1:0] exp_pm;
        bit clr_ae, clr_nmi;
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        addr_err_evt = ae_e; nmi_evt = nmi_e; standby = sb;
        ch_de = de; ch_te = te;
        #1;
        exp_rd = '0;
        exp_rd[0] = m_en; exp_rd[1] = m_nmi; exp_rd[2] = m_ae;
        exp_pm = (m_en && !m_ae && !m_nmi) ? (de & ~te) : '0;
        check(ph, "R1 rdata", reg_rdata, exp_rd);
        check(ph, "R2 permit", DW'(ch_permit), DW'(exp_pm));
        check(ph, "R6 abort", DW'(abort_pulse), DW'(m_en_prev & ~m_en));
        @(posedge clk);
        clr_ae  = wr && !wd[2] && m_arm_ae;
        clr_nmi = wr && !wd[1] && m_arm_nmi;
        m_arm_ae  = sb ? 0 : clr_ae  ? 0 : ((rd && m_ae)  ? 1 : m_arm_ae);
        m_arm_nmi = sb ? 0 : clr_nmi ? 0 : ((rd && m_nmi) ? 1 : m_arm_nmi);
        m_ae  = sb ? 0 : ae_e  ? 1 : clr_ae  ? 0 : m_ae;
        m_nmi = sb ? 0 : nmi_e ? 1 : clr_nmi ? 0 : m_nmi;
        if (!m_ae)  m_arm_ae  = 0;
        if (!m_nmi) m_arm_nmi = 0;
        m_en_prev = m_en;
        if (wr) m_en = wd[0];
    endtask

    task automatic idle(string ph);
        step(ph, 0, 0, '0, 0, 0, 0, '1, '0);
    endtask

    task automatic wr(string ph, logic [DW-1:0] wd);
        step(ph, 0, 1, wd, 0, 0, 0, '1, '0);
    endtask

    task automatic rd(string ph);
        step(ph, 1, 0, '0, 0, 0, 0, '1, '0);
    endtask

    task automatic sweep(string ph);
        for (int d = 0; d < 16; d++)
            for (int t = 0; t < 16; t++)
                step(ph, 0, 0, '0, 0, 0, 0, NC'(d), NC'(t));
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_en = 0; m_en_prev = 0; m_ae = 0; m_nmi = 0; m_arm_ae = 0; m_arm_nmi = 0;
        // R5: during reset, even with events present
        @(negedge clk); addr_err_evt = 1; nmi_evt = 1; reg_wr = 1; reg_wdata = '1;
        repeat (3) @(negedge clk);
        check("R5", "rdata in reset", reg_rdata, '0);
        addr_err_evt = 0; nmi_evt = 0; reg_wr = 0; reg_wdata = '0;
        rst_n = 1;
        idle("R5");

        // R1 / R9: writing all ones sets only the enable
        wr("R1", 8'hFF);
        idle("R1");
        check("R1", "upper and flag bits after write of ones", reg_rdata, 8'h01);
        // R2: enable on, no flags, full sweep; then enable off
        sweep("R2");
        wr("R9", 8'h00);
        sweep("R2");
        wr("R9", 8'h01);

        // R7 / R3: address error blocks everything
        step("R7", 0, 0, '0, 1, 0, 0, '1, '0);
        sweep("R3");
        // R4: write 0 without a prior read, then a write of 1
        wr("R4", 8'h01);
        wr("R4", 8'h05);
        idle("R4");
        check("R4", "aerr still set", DW'(reg_rdata[2]), 1);
        rd("R4");
        wr("R4", 8'h01);
        idle("R4");
        check("R4", "aerr cleared", DW'(reg_rdata[2]), 0);

        // R7 / R3: interrupt flag
        step("R7", 0, 0, '0, 0, 1, 0, '1, '0);
        sweep("R3");
        rd("R4");
        wr("R4", 8'h01);
        idle("R4");

        // R10: read arms only address error; interrupt set afterwards survives
        step("R10", 0, 0, '0, 1, 0, 0, '1, '0);
        rd("R10");
        step("R10", 0, 0, '0, 0, 1, 0, '1, '0);
        wr("R10", 8'h01);
        idle("R10");
        check("R10", "nmi kept, aerr cleared", reg_rdata, 8'h03);
        rd("R10");
        wr("R10", 8'h01);
        idle("R10");

        // R8: event collides with the clearing write
        step("R8", 0, 0, '0, 1, 0, 0, '1, '0);
        rd("R8");
        step("R8", 0, 1, 8'h01, 1, 0, 0, '1, '0);
        wr("R8", 8'h01);
        idle("R8");
        check("R8", "marker consumed, flag held", DW'(reg_rdata[2]), 1);
        rd("R8");
        wr("R8", 8'h01);
        idle("R8");

        // R5: standby wipes the flags and the markers
        step("R5", 0, 0, '0, 1, 1, 0, '1, '0);
        rd("R5");
        step("R5", 0, 0, '0, 1, 0, 1, '1, '0);
        idle("R5");
        check("R5", "flags after standby", reg_rdata, 8'h01);
        step("R5", 0, 0, '0, 1, 0, 0, '1, '0);
        wr("R5", 8'h01);
        idle("R5");
        check("R5", "stale marker not reused", DW'(reg_rdata[2]), 1);
        rd("R5");
        wr("R5", 8'h01);

        // R6: clear the enable with channels running
        sweep("R2");
        wr("R6", 8'h00);
        idle("R6");
        idle("R6");
        wr("R6", 8'h01);
        wr("R6", 8'h00);
        idle("R6");

        // mixed random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            r = $urandom;
            step("mix", r[1:0] == 0, r[3:2] == 0, DW'(r[11:4]),
                 r[14:12] == 0, r[17:15] == 0, r[22:18] == 0,
                 NC'(r[26:23]), NC'(r[30:27]));
        end

        summary();
        $finish;
    end
endmodule